// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 12-bit charge-redistribution successive-approximation converter. It steps through a fixed 15-period conversion cycle. The first three periods track the input and auto-zero the comparator. The remaining twelve periods each try one bit of a binary trial code, from the most significant bit down to the least. The trial code drives the capacitor switches. A single-bit comparator result decides whether each tried bit is kept.

When the last bit is decided, the full code is moved into a holding register. That register keeps the value through the whole next conversion. A ready flag marks the first period of the following cycle.

An active-low start input selects the mode. Held low, it makes cycles run back to back. Left high across the first period, it makes the sequencer park in period 2. While parked, the block keeps tracking, keeps the ready flag up and withdraws its request for a running clock. A low start pulse then resumes the cycle directly at period 3. The capacitor array, the comparator and the clock source sit outside this block.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The `period` output counts 1,2,...,15 as 4-bit binary, one step per rising clock edge, and wraps from 15 back to 1.
- R2: In periods 1 to 3, `track` is high and `trial` is all zeros. From period 4 to period 15, `track` is low.
- R3: On entry to period 4, `trial` equals 12'h800: bit 11 set, all others clear.
- R4: At the end of each period k from 4 to 15, bit (15-k) of `trial` keeps its 1 if `cmp_hi` is high and is cleared if it is low. Bit (14-k) is then set, and earlier decisions are kept. With an ideal comparator (`cmp_hi` = input code >= `trial`), the result equals the input code.
- R5: `result` is loaded only at the edge that ends period 15. At every other edge it holds its value.
- R6: `data_rdy` is high during period 1 that follows a completed conversion. In continuous operation it is low from period 2 onward.
- R7: `start_n` is sampled only at the end of period 1 and while parked. Changes of `start_n` during periods 2 to 15 of a running cycle do not alter the sequence.
- R8: If `start_n` is high at the end of period 1, the sequencer parks in period 2. While parked, `track` stays high, `data_rdy` keeps its value and `clk_run` is low.
- R9: While parked, a low `start_n` drops `data_rdy` and raises `clk_run` in the same cycle. The next rising edge moves the sequencer to period 3.
- R10: While `rst_n` is low, `period` is 1, `trial` and `result` are 0, `data_rdy` is 0 and `clk_run` is 1.
- R11: The code is straight binary with bit 11 as MSB: input code 0 gives 0, and full scale gives 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_n | input | 1 | Active-low start / run-continuously request |
| cmp_hi | input | 1 | Comparator decision for the current trial code |
| track | output | 1 | Track/auto-zero phase: switches select the input |
| trial | output | 12 | Trial code driving the capacitor switches |
| result | output | 12 | Last completed conversion code |
| data_rdy | output | 1 | New result available |
| clk_run | output | 1 | Request for the conversion clock to keep running |
| period | output | 4 | Current period number (debug) |

## Verification
The assertions assume that `start_n` and `cmp_hi` are synchronous to `clk` and settle well before each rising edge. They also assume that the clock keeps running even while `clk_run` is low, because gating it is left to the surrounding logic. The bench drives both inputs only on falling edges. It models the comparator as a combinational compare of a held input code against `trial`, and changes that code only during the track periods or while parked. Start pulses in single-shot tests last one full clock period, so each is seen at exactly one edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned SEQ_BITS  = 12;
  localparam int unsigned SEQ_TRACK = 3;

  function automatic int unsigned period_width(input int unsigned nbits, input int unsigned ntrack);
    return $clog2(nbits + ntrack + 1);
  endfunction
endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
  import sar_seq_pkg::*;
#(
  parameter int unsigned N_BITS  = SEQ_BITS,
  parameter int unsigned N_TRACK = SEQ_TRACK,
  localparam int unsigned PW     = period_width(N_BITS, N_TRACK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_n,
  output logic [PW-1:0] period,
  output logic          parked,
  output logic          rdy
);
  localparam logic [PW-1:0] P_FIRST = PW'(1);
  localparam logic [PW-1:0] P_PARK  = PW'(2);
  localparam logic [PW-1:0] P_RESUME = PW'(3);
  localparam logic [PW-1:0] P_LAST  = PW'(N_TRACK + N_BITS);

  logic [PW-1:0] period_q, period_d;
  logic          parked_q, parked_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    period_d = period_q;
    parked_d = parked_q;
    rdy_d    = rdy_q;
    if (parked_q) begin
      if (!start_n) begin
        period_d = P_RESUME;
        parked_d = 1'b0;
        rdy_d    = 1'b0;
      end
    end else if (period_q == P_FIRST) begin
      period_d = P_PARK;
      if (start_n) parked_d = 1'b1;
      else         rdy_d    = 1'b0;
    end else if (period_q == P_LAST) begin
      period_d = P_FIRST;
      rdy_d    = 1'b1;
    end else begin
      period_d = period_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= P_FIRST;
      parked_q <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      period_q <= period_d;
      parked_q <= parked_d;
      rdy_q    <= rdy_d;
    end
  end

  assign period = period_q;
  assign parked = parked_q;
  assign rdy    = rdy_q;
endmodule

// File: rtl/sar_seq_approx.sv
module sar_seq_approx
  import sar_seq_pkg::*;
#(
  parameter int unsigned N_BITS  = SEQ_BITS,
  parameter int unsigned N_TRACK = SEQ_TRACK,
  localparam int unsigned PW     = period_width(N_BITS, N_TRACK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     period,
  input  logic              cmp_hi,
  output logic [N_BITS-1:0] trial,
  output logic [N_BITS-1:0] result
);
  localparam logic [PW-1:0] P_TRACK_END = PW'(N_TRACK);
  localparam logic [PW-1:0] P_LAST      = PW'(N_TRACK + N_BITS);
  localparam int            LAST_I      = int'(N_TRACK + N_BITS);

  logic [N_BITS-1:0] trial_q, trial_d;
  logic [N_BITS-1:0] result_q, result_d;
  logic              res_en;
  int                idx;

  always_comb begin
    trial_d  = trial_q;
    result_d = result_q;
    res_en   = 1'b0;
    idx      = LAST_I - int'(period);
    if (period == P_TRACK_END) begin
      trial_d             = '0;
      trial_d[N_BITS-1]   = 1'b1;
    end else if (period > P_TRACK_END && period <= P_LAST) begin
      for (int b = 0; b < int'(N_BITS); b++) begin
        if (b == idx)          trial_d[b] = cmp_hi;
        else if (b + 1 == idx) trial_d[b] = 1'b1;
      end
      if (period == P_LAST) begin
        res_en   = 1'b1;
        result_d = trial_d;
        trial_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
    end else begin
      trial_q <= trial_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (res_en) begin
      result_q <= result_d;
    end
  end

  assign trial  = trial_q;
  assign result = result_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned N_BITS  = SEQ_BITS,
  parameter int unsigned N_TRACK = SEQ_TRACK,
  localparam int unsigned PW     = period_width(N_BITS, N_TRACK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              cmp_hi,
  output logic              track,
  output logic [N_BITS-1:0] trial,
  output logic [N_BITS-1:0] result,
  output logic              data_rdy,
  output logic              clk_run,
  output logic [PW-1:0]     period
);
  localparam logic [PW-1:0] P_TRACK_END = PW'(N_TRACK);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       parked;
  logic       rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sar_seq_timer #(.N_BITS(N_BITS), .N_TRACK(N_TRACK)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_n (start_n),
    .period  (period),
    .parked  (parked),
    .rdy     (rdy)
  );

  sar_seq_approx #(.N_BITS(N_BITS), .N_TRACK(N_TRACK)) u_approx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .period (period),
    .cmp_hi (cmp_hi),
    .trial  (trial),
    .result (result)
  );

  assign track    = (period <= P_TRACK_END);
  assign data_rdy = rdy & ~(parked & ~start_n);
  assign clk_run  = ~parked | ~start_n;
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk
  import sar_seq_pkg::*;
#(
  parameter int unsigned N_BITS  = SEQ_BITS,
  parameter int unsigned N_TRACK = SEQ_TRACK,
  localparam int unsigned PW     = period_width(N_BITS, N_TRACK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_n,
  input logic              track,
  input logic [N_BITS-1:0] trial,
  input logic [N_BITS-1:0] result,
  input logic              data_rdy,
  input logic              clk_run,
  input logic [PW-1:0]     period
);
  localparam logic [PW-1:0] P_FIRST     = PW'(1);
  localparam logic [PW-1:0] P_PARK      = PW'(2);
  localparam logic [PW-1:0] P_TRACK_END = PW'(N_TRACK);
  localparam logic [PW-1:0] P_DECIDE1   = PW'(N_TRACK + 1);
  localparam logic [PW-1:0] P_LAST      = PW'(N_TRACK + N_BITS);
  localparam logic [N_BITS-1:0] MSB_ONLY = {1'b1, {(N_BITS-1){1'b0}}};

  assert_period_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    period >= P_FIRST && period <= P_LAST);

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (period == P_LAST) |=> (period == P_FIRST));

  assert_track_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    track |-> (trial == '0 && period <= P_TRACK_END));

  assert_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (period == P_DECIDE1) |-> (trial == MSB_ONLY));

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (period != P_LAST) |=> $stable(result));

  assert_ready_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |-> (period == P_FIRST || period == P_PARK));

  assert_park_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run |-> (period == P_PARK && track && start_n));

  assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period == P_PARK && !clk_run) ##1 (period == P_PARK && !start_n) |=> (period == PW'(3)));
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.N_BITS(N_BITS), .N_TRACK(N_TRACK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_n  (start_n),
  .track    (track),
  .trial    (trial),
  .result   (result),
  .data_rdy (data_rdy),
  .clk_run  (clk_run),
  .period   (period)
);

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        start_n;
  logic        cmp_hi;
  logic        track;
  logic [11:0] trial;
  logic [11:0] result;
  logic        data_rdy;
  logic        clk_run;
  logic [3:0]  period;
  logic [11:0] vin;

  int checks;
  int errors;

  sar_seq_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_n  (start_n),
    .cmp_hi   (cmp_hi),
    .track    (track),
    .trial    (trial),
    .result   (result),
    .data_rdy (data_rdy),
    .clk_run  (clk_run),
    .period   (period)
  );

  // ideal comparator model of the analog array
  assign cmp_hi = (vin >= trial);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_period(input int p);
    do @(negedge clk); while (int'(period) != p);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start_n = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    chk("R10", "period", int'(period), 1);
    chk("R10", "trial", int'(trial), 0);
    chk("R10", "result", int'(result), 0);
    chk("R10", "data_rdy", int'(data_rdy), 0);
    chk("R10", "clk_run", int'(clk_run), 1);
    chk("R2", "track in reset", int'(track), 1);
    rst_n = 1'b1;
  endtask

  // one continuous conversion; entered during tracking, leaves in period 2
  task automatic test_conv(input logic [11:0] code, input string req);
    vin = code;
    wait_period(4);
    chk("R3", "trial at period 4", int'(trial), 12'h800);
    chk("R2", "track at period 4", int'(track), 0);
    wait_period(15);
    @(negedge clk);
    chk("R1", "wrap to 1", int'(period), 1);
    chk(req, "result", int'(result), int'(code));
    chk("R6", "data_rdy in period 1", int'(data_rdy), 1);
    chk("R2", "trial cleared in period 1", int'(trial), 0);
    @(negedge clk);
    chk("R6", "data_rdy in period 2", int'(data_rdy), 0);
    chk("R5", "result held in period 2", int'(result), int'(code));
  endtask

  task automatic test_period_steps();
    wait_period(5);
    for (int p = 6; p <= 15; p++) begin
      @(negedge clk);
      chk("R1", "period step", int'(period), p);
    end
    wait_period(2);
  endtask

  task automatic test_start_ignored(input logic [11:0] code);
    vin = code;
    wait_period(6);
    start_n = 1'b1;
    @(negedge clk);
    chk("R7", "period with start high", int'(period), 7);
    @(negedge clk);
    start_n = 1'b0;
    chk("R7", "clk_run mid-cycle", int'(clk_run), 1);
    wait_period(15);
    @(negedge clk);
    chk("R7", "result after start toggle", int'(result), int'(code));
    @(negedge clk);
  endtask

  task automatic test_single_shot(input logic [11:0] c1, input logic [11:0] c2);
    vin = c1;
    start_n = 1'b1;
    wait_period(15);
    @(negedge clk);
    chk("R6", "data_rdy period 1 single", int'(data_rdy), 1);
    @(negedge clk);
    chk("R8", "parked period", int'(period), 2);
    chk("R8", "clk_run parked", int'(clk_run), 0);
    chk("R8", "data_rdy parked", int'(data_rdy), 1);
    chk("R8", "track parked", int'(track), 1);
    repeat (5) @(negedge clk);
    chk("R8", "still parked", int'(period), 2);
    chk("R5", "result held parked", int'(result), int'(c1));
    start_n = 1'b0;
    #1;
    chk("R9", "data_rdy drops on start", int'(data_rdy), 0);
    chk("R9", "clk_run on start", int'(clk_run), 1);
    @(negedge clk);
    start_n = 1'b1;
    vin = c2;
    chk("R9", "resume at period 3", int'(period), 3);
    chk("R9", "data_rdy after resume", int'(data_rdy), 0);
    wait_period(15);
    @(negedge clk);
    chk("R4", "single-shot result", int'(result), int'(c2));
    @(negedge clk);
    chk("R8", "parked again", int'(clk_run), 0);
    start_n = 1'b0;
    @(negedge clk);
    chk("R9", "resume again", int'(period), 3);
    wait_period(2);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    test_reset();
    test_conv(12'd0,    "R11");
    test_conv(12'd4095, "R11");
    test_conv(12'd2048, "R4");
    test_conv(12'd1365, "R4");
    test_conv(12'd2730, "R4");
    test_conv(12'd1,    "R4");
    test_period_steps();
    test_start_ignored(12'd3071);
    test_single_shot(12'd1234, 12'd4094);
    test_conv(12'd777, "R4");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule